// File: doc/BRIEF.md
# Paging and Mode Control Register Unit

This unit holds the three control registers that govern address translation and operating mode in a 32-bit core: the mode word, the translation base and the feature word. It also holds the gate state of address line 20. On every write it works out the effect on translation. It keeps a small set of derived mode flags for the rest of the core, and it raises a one-cycle flush request whenever a write changes a bit that the address translation cache depends on.

The address-line-20 gate arrives as a level input. Any nonzero value counts as "line enabled". The unit turns the gate into a 32-bit mask that the memory path ANDs with every physical address. When the gate state changes, the unit asks the core to leave its current execution block and flush all translations. Register writes use one port: a select, a data word and a strobe. Only one register is written per strobe.

Top module: `mode_ctl_unit`

## Requirements
- R1: After reset: mode word = 0x60000010, translation base = 0, feature word = 0, A20 mask = 0xFFFFFFFF, derived flags = 5'b00010, flush and exit low.
- R2: A write with select 0 stores the data in the mode word with bit 4 forced to 1. It is visible on the cycle after the strobe.
- R3: A select-0 write raises flush on the cycle after the strobe only if bit 31, bit 16 or bit 0 of the data differs from the stored mode word.
- R4: Derived flag bit 0 equals mode word bit 0. Derived flag bit 1 is 1 when mode word bit 0 is 0, and 0 otherwise.
- R5: Derived flag bits 2, 3 and 4 take mode word bits 1, 2 and 3 on each select-0 write.
- R6: A select-1 write always stores the translation base. It raises flush only if mode word bit 31 is set at the time of the write.
- R7: A select-2 write stores the feature word as written. It raises flush only if bit 4, 5 or 7 changes.
- R8: The A20 mask equals 0xFFEFFFFF OR (g << 20), where g is 1 when the gate input is nonzero and 0 otherwise.
- R9: When g differs from the stored gate state, the state updates and both exit and flush pulse on the next cycle. A new nonzero gate value while the state is already 1 causes no pulse and no mask change.
- R10: A strobe with select 3, or select and data presented while the strobe is low, changes no register and raises no pulse.
- R11: Flush and exit are single-cycle pulses. They fall in the cycle after they rise unless a new cause arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Register select: 0 mode, 1 translation base, 2 feature, 3 none |
| wr_data_i | input | 32 | Write data |
| a20_gate_i | input | GATE_W | Address-line-20 gate level, nonzero = enabled |
| cr0_o | output | 32 | Mode word |
| cr3_o | output | 32 | Translation base |
| cr4_o | output | 32 | Feature word |
| hflags_o | output | 5 | Derived flags {ts, em, mp, addseg, pe} |
| a20_mask_o | output | 32 | Physical address mask |
| flush_o | output | 1 | Translation flush pulse |
| exit_o | output | 1 | Execution-exit pulse |

## Verification
The bench targets writes that change only bits outside the watched sets. An example is a feature-word write that flips bit 9 or bit 3 but leaves bit 4 set; a design with a wrong mask would flush there, or would miss the flush when bit 5 or bit 7 toggles. The bench writes the translation base with paging both off and on, to catch a design that flushes unconditionally or never. It also steps the gate through a second nonzero value: a design that compares raw gate values instead of the reduced state would pulse exit falsely. Finally it writes select 3 and presents data with the strobe low, to expose decoders that leak writes.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_XBASE = 2'd1,
    SEL_FEAT  = 2'd2,
    SEL_NONE  = 2'd3
  } cr_sel_e;

  // mode word bit positions
  localparam int MB_PE = 0;
  localparam int MB_MP = 1;
  localparam int MB_EM = 2;
  localparam int MB_TS = 3;
  localparam int MB_ET = 4;
  localparam int MB_WP = 16;
  localparam int MB_PG = 31;

  // feature word bit positions
  localparam int FB_PSE = 4;
  localparam int FB_PAE = 5;
  localparam int FB_PGE = 7;

  localparam int A20_BIT = 20;

  localparam logic [XLEN-1:0] MODE_RESET = 32'h6000_0010;
  localparam logic [XLEN-1:0] MODE_WATCH = (XLEN'(1) << MB_PG) | (XLEN'(1) << MB_WP) | (XLEN'(1) << MB_PE);
  localparam logic [XLEN-1:0] FEAT_WATCH = (XLEN'(1) << FB_PGE) | (XLEN'(1) << FB_PAE) | (XLEN'(1) << FB_PSE);

  typedef struct packed {
    logic ts;
    logic em;
    logic mp;
    logic addseg;
    logic pe;
  } hflags_t;
endpackage

// File: rtl/mcu_mode_reg.sv
module mcu_mode_reg
  import mcu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] cr0_o,
  output hflags_t         hflags_o,
  output logic            chg_o
);
  logic [XLEN-1:0] cr0_q, cr0_d;
  hflags_t         hf_q, hf_d;

  always_comb begin
    cr0_d = data_i | (XLEN'(1) << MB_ET);
    hf_d.pe     = data_i[MB_PE];
    hf_d.addseg = ~data_i[MB_PE];
    hf_d.mp     = data_i[MB_MP];
    hf_d.em     = data_i[MB_EM];
    hf_d.ts     = data_i[MB_TS];
    chg_o = wr_i && (((data_i ^ cr0_q) & MODE_WATCH) != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr0_q <= MODE_RESET;
      hf_q  <= '{ts: 1'b0, em: 1'b0, mp: 1'b0, addseg: 1'b1, pe: 1'b0};
    end else if (wr_i) begin
      cr0_q <= cr0_d;
      hf_q  <= hf_d;
    end
  end

  assign cr0_o    = cr0_q;
  assign hflags_o = hf_q;
endmodule

// File: rtl/mcu_paging_regs.sv
module mcu_paging_regs
  import mcu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_base_i,
  input  logic            wr_feat_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            pg_i,
  output logic [XLEN-1:0] cr3_o,
  output logic [XLEN-1:0] cr4_o,
  output logic            chg_o
);
  logic [XLEN-1:0] cr3_q, cr4_q;
  logic            base_chg, feat_chg;

  always_comb begin
    base_chg = wr_base_i && pg_i;
    feat_chg = wr_feat_i && (((data_i ^ cr4_q) & FEAT_WATCH) != '0);
    chg_o    = base_chg || feat_chg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr3_q <= '0;
    end else if (wr_base_i) begin
      cr3_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr4_q <= '0;
    end else if (wr_feat_i) begin
      cr4_q <= data_i;
    end
  end

  assign cr3_o = cr3_q;
  assign cr4_o = cr4_q;
endmodule

// File: rtl/mcu_a20_gate.sv
module mcu_a20_gate
  import mcu_pkg::*;
#(
  parameter int GATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GATE_W-1:0] gate_i,
  output logic [XLEN-1:0]   mask_o,
  output logic              chg_o
);
  localparam logic [XLEN-1:0] BASE_MASK = ~(XLEN'(1) << A20_BIT);

  logic state_q, state_d;

  always_comb begin
    state_d = |gate_i;
    chg_o   = state_d != state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b1;
    end else if (chg_o) begin
      state_q <= state_d;
    end
  end

  assign mask_o = BASE_MASK | (XLEN'(state_q) << A20_BIT);
endmodule

// File: rtl/mode_ctl_unit.sv
module mode_ctl_unit
  import mcu_pkg::*;
#(
  parameter int GATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic [GATE_W-1:0] a20_gate_i,
  output logic [XLEN-1:0]   cr0_o,
  output logic [XLEN-1:0]   cr3_o,
  output logic [XLEN-1:0]   cr4_o,
  output logic [4:0]        hflags_o,
  output logic [XLEN-1:0]   a20_mask_o,
  output logic              flush_o,
  output logic              exit_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;
  logic       wr_mode, wr_base, wr_feat;
  logic       mode_chg, page_chg, a20_chg;
  logic       flush_d, exit_d, flush_q, exit_q;
  hflags_t    hf;
  cr_sel_e    sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync_q[1];

  always_comb begin
    sel     = cr_sel_e'(wr_sel_i);
    wr_mode = wr_en_i && (sel == SEL_MODE);
    wr_base = wr_en_i && (sel == SEL_XBASE);
    wr_feat = wr_en_i && (sel == SEL_FEAT);
  end

  mcu_mode_reg u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .wr_i     (wr_mode),
    .data_i   (wr_data_i),
    .cr0_o    (cr0_o),
    .hflags_o (hf),
    .chg_o    (mode_chg)
  );

  mcu_paging_regs u_page (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .wr_base_i (wr_base),
    .wr_feat_i (wr_feat),
    .data_i    (wr_data_i),
    .pg_i      (cr0_o[MB_PG]),
    .cr3_o     (cr3_o),
    .cr4_o     (cr4_o),
    .chg_o     (page_chg)
  );

  mcu_a20_gate #(.GATE_W(GATE_W)) u_a20 (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .gate_i (a20_gate_i),
    .mask_o (a20_mask_o),
    .chg_o  (a20_chg)
  );

  always_comb begin
    flush_d = mode_chg || page_chg || a20_chg;
    exit_d  = a20_chg;
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      flush_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      flush_q <= flush_d;
      exit_q  <= exit_d;
    end
  end

  assign flush_o  = flush_q;
  assign exit_o   = exit_q;
  assign hflags_o = hf;
endmodule

// File: rtl/mcu_chk.sv
module mcu_chk #(
  parameter int GATE_W = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [31:0]       wr_data_i,
  input logic [GATE_W-1:0] a20_gate_i,
  input logic [31:0]       cr0_o,
  input logic [31:0]       cr3_o,
  input logic [31:0]       cr4_o,
  input logic [31:0]       a20_mask_o,
  input logic              flush_o,
  input logic              exit_o
);
  logic gate_same;
  assign gate_same = (|a20_gate_i) == a20_mask_o[20];

  // R2
  mode_store_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd0) |=> (cr0_o == ($past(wr_data_i) | 32'h10)));

  // R3
  mode_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd0 && ((wr_data_i ^ cr0_o) & 32'h8001_0001) != 32'h0) |=> flush_o);

  // R6
  base_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd1 && cr0_o[31]) |=> flush_o);

  // R6
  base_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd1 && !cr0_o[31] && gate_same) |=> !flush_o);

  // R9
  gate_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !gate_same |=> (exit_o && flush_o));

  // R10
  no_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd3 && gate_same) |=>
      ($stable(cr0_o) && $stable(cr3_o) && $stable(cr4_o) && !flush_o && !exit_o));
endmodule

bind mode_ctl_unit mcu_chk #(.GATE_W(GATE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_sync),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .a20_gate_i (a20_gate_i),
  .cr0_o      (cr0_o),
  .cr3_o      (cr3_o),
  .cr4_o      (cr4_o),
  .a20_mask_o (a20_mask_o),
  .flush_o    (flush_o),
  .exit_o     (exit_o)
);

// File: tb/mode_ctl_unit_tb.sv
`timescale 1ns/1ps
module mode_ctl_unit_tb;
  localparam int GATE_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              wr_en_i;
  logic [1:0]        wr_sel_i;
  logic [31:0]       wr_data_i;
  logic [GATE_W-1:0] a20_gate_i;
  logic [31:0]       cr0_o, cr3_o, cr4_o, a20_mask_o;
  logic [4:0]        hflags_o;
  logic              flush_o, exit_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mode_ctl_unit #(.GATE_W(GATE_W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .a20_gate_i (a20_gate_i),
    .cr0_o      (cr0_o),
    .cr3_o      (cr3_o),
    .cr4_o      (cr4_o),
    .hflags_o   (hflags_o),
    .a20_mask_o (a20_mask_o),
    .flush_o    (flush_o),
    .exit_o     (exit_o)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [31:0] data;
    logic [7:0]  gate;
    logic [31:0] exp_rd;
    logic [31:0] exp_mask;
    logic        exp_flush;
    logic        exp_exit;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R2 R3: PE on -> flush
    '{1'b1, 2'd0, 32'h0000_0001, 8'h01, 32'h0000_0011, 32'hFFFF_FFFF, 1'b1, 1'b0},
    // R3: PE off -> flush
    '{1'b1, 2'd0, 32'h0000_000E, 8'h01, 32'h0000_001E, 32'hFFFF_FFFF, 1'b1, 1'b0},
    // R3: only unwatched bits change
    '{1'b1, 2'd0, 32'h0000_002E, 8'h01, 32'h0000_003E, 32'hFFFF_FFFF, 1'b0, 1'b0},
    // R6: paging off
    '{1'b1, 2'd1, 32'h1234_5000, 8'h01, 32'h1234_5000, 32'hFFFF_FFFF, 1'b0, 1'b0},
    // R3: PG, WP, PE set
    '{1'b1, 2'd0, 32'h8001_0001, 8'h01, 32'h8001_0011, 32'hFFFF_FFFF, 1'b1, 1'b0},
    // R6: paging on
    '{1'b1, 2'd1, 32'h0ABC_D000, 8'h01, 32'h0ABC_D000, 32'hFFFF_FFFF, 1'b1, 1'b0},
    // R7: bit 4 set
    '{1'b1, 2'd2, 32'h0000_0010, 8'h01, 32'h0000_0010, 32'hFFFF_FFFF, 1'b1, 1'b0},
    // R7: bits 9 and 3 only
    '{1'b1, 2'd2, 32'h0000_0218, 8'h01, 32'h0000_0218, 32'hFFFF_FFFF, 1'b0, 1'b0},
    // R7: bits 7 and 5
    '{1'b1, 2'd2, 32'h0000_00B8, 8'h01, 32'h0000_00B8, 32'hFFFF_FFFF, 1'b1, 1'b0},
    // R10: select 3
    '{1'b1, 2'd3, 32'hFFFF_FFFF, 8'h01, 32'h8001_0011, 32'hFFFF_FFFF, 1'b0, 1'b0},
    // R3: WP cleared
    '{1'b1, 2'd0, 32'h8000_0001, 8'h01, 32'h8000_0011, 32'hFFFF_FFFF, 1'b1, 1'b0},
    // R8 R9: gate to 0
    '{1'b0, 2'd0, 32'h0000_0000, 8'h00, 32'h8000_0011, 32'hFFEF_FFFF, 1'b1, 1'b1},
    // R9: gate held 0
    '{1'b0, 2'd0, 32'h0000_0000, 8'h00, 32'h8000_0011, 32'hFFEF_FFFF, 1'b0, 1'b0},
    // R8 R9: gate to 0x40
    '{1'b0, 2'd0, 32'h0000_0000, 8'h40, 32'h8000_0011, 32'hFFFF_FFFF, 1'b1, 1'b1},
    // R9: other nonzero value
    '{1'b0, 2'd0, 32'h0000_0000, 8'h80, 32'h8000_0011, 32'hFFFF_FFFF, 1'b0, 1'b0},
    // R9: quiet write with gate change
    '{1'b1, 2'd0, 32'h8000_0011, 8'h00, 32'h8000_0011, 32'hFFEF_FFFF, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] data, input logic [7:0] gate);
    wr_en_i    = we;
    wr_sel_i   = sel;
    wr_data_i  = data;
    a20_gate_i = gate;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    rst_ni     = 1'b0;
    wr_en_i    = 1'b0;
    wr_sel_i   = 2'd0;
    wr_data_i  = '0;
    a20_gate_i = 8'h01;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 cr0",   cr0_o, 32'h6000_0010);
    chk("R1 cr3",   cr3_o, 32'h0);
    chk("R1 cr4",   cr4_o, 32'h0);
    chk("R1 mask",  a20_mask_o, 32'hFFFF_FFFF);
    chk("R1 flags", {27'h0, hflags_o}, 32'h2);
    chk("R1 flush", {31'h0, flush_o}, 32'h0);
    chk("R1 exit",  {31'h0, exit_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] rd;
      step(VECS[i].we, VECS[i].sel, VECS[i].data, VECS[i].gate);
      case (VECS[i].sel)
        2'd1:    rd = cr3_o;
        2'd2:    rd = cr4_o;
        default: rd = cr0_o;
      endcase
      chk($sformatf("R2/R6/R7/R10 value v%0d", i), rd, VECS[i].exp_rd);
      chk($sformatf("R8 mask v%0d", i), a20_mask_o, VECS[i].exp_mask);
      chk($sformatf("R3/R6/R7/R9 flush v%0d", i), {31'h0, flush_o}, {31'h0, VECS[i].exp_flush});
      chk($sformatf("R9 exit v%0d", i), {31'h0, exit_o}, {31'h0, VECS[i].exp_exit});
    end

    // R11: pulses drop after one cycle
    step(1'b0, 2'd0, 32'h0, 8'h00);
    chk("R11 flush low", {31'h0, flush_o}, 32'h0);
    chk("R11 exit low",  {31'h0, exit_o}, 32'h0);

    // R10: data presented with strobe low
    step(1'b0, 2'd0, 32'h0000_0000, 8'h00);
    chk("R10 cr0 kept", cr0_o, 32'h8000_0011);
    chk("R10 no flush", {31'h0, flush_o}, 32'h0);

    // R4 R5: flags from mode word
    step(1'b1, 2'd0, 32'h0000_000A, 8'h00);
    chk("R2 cr0", cr0_o, 32'h0000_001A);
    chk("R4/R5 flags A", {27'h0, hflags_o}, 32'h16);
    step(1'b0, 2'd0, 32'h0, 8'h00);
    chk("R11 flush cleared", {31'h0, flush_o}, 32'h0);
    step(1'b1, 2'd0, 32'h0000_0005, 8'h00);
    chk("R4/R5 flags 5", {27'h0, hflags_o}, 32'h09);
    chk("R3 flush PE", {31'h0, flush_o}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule